// File: doc/BRIEF.md
# OLED Power-Up Command Sequencer

This block brings a small I2C-attached OLED display module into and out of operation. A power-up request makes it hold the module's active-low reset line low for a timed minimum pulse and then release it. It then writes one I2C frame to the module: the slave address, a control byte that marks the next byte as a command, and the display-on command. After that frame it waits out the panel settling time and only then raises `ready`. A power-down request, accepted only while the display is on, sends the same kind of frame carrying the display-off command and returns the reset line to its held-low state.

The block drives the bus in open-drain style. It only ever pulls SCL or SDA low, or lets them go, and it reads SDA back for the acknowledge bit. A frame that sees a NACK on any byte ends at once with a stop condition and reports an error together with `done`. The acknowledge check can be turned off by a parameter for boards where the acknowledge path is not wired. The reset pulse, the settling wait and the SCL rate all come from time parameters that are converted to clock cycles.

Top module: `oled_pwr_seq`

## Requirements
- R1: After reset, `rst_n_out` is 0, `ready`, `busy`, `done` and `err` are 0, and both `scl_low` and `sda_low` are 0 (bus released).
- R2: An accepted power-up request keeps `rst_n_out` low for at least the reset cycle count (ceil of CLK_KHZ·RST_NS/10^6) and then drives it high. The bus stays released while `rst_n_out` is low.
- R3: A power-up frame is one start, three bytes sent MSB first, and one stop. The bytes are the address byte `{6'b011110, addr_sel, 1'b0}`, then 0x00, then 0xAF.
- R4: After a fully acknowledged power-up frame, `ready` rises no earlier than the settle cycle count (CLK_KHZ·SETTLE_US/1000) after the stop condition. At that same edge `done` pulses for one cycle with `err` = 0.
- R5: A power-down request while `ready` is 1 drops `ready` on the next cycle. It sends start, the address byte, 0x00, 0xAE and stop, then pulses `done` and returns `rst_n_out` to 0.
- R6: If the addressed device leaves SDA high in the acknowledge slot of any byte, no further byte is sent. A stop follows, and `done` pulses with `err` = 1. The block returns to the reset-held state with `ready` = 0.
- R7: With CHECK_ACK = 0, a missing acknowledge has no effect: the full power-up frame is sent, `err` stays 0 and `ready` rises.
- R8: A power-up request while the display is on or a sequence is running is ignored, and so is a power-down request while the display is off. Neither starts bus traffic nor changes `ready`, `busy` or `rst_n_out`.
- R9: `busy` is 1 from the cycle after a request is accepted until the cycle in which `done` pulses, and it is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Power-up request, one-cycle pulse |
| down_req | input | 1 | Power-down request, one-cycle pulse |
| addr_sel | input | 1 | Address-select bit placed in the address byte, captured at request |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| rst_n_out | output | 1 | Active-low reset to the display module |
| ready | output | 1 | Display on and settled |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of each sequence |
| err | output | 1 | Last sequence ended on a NACK; cleared by the next accepted request |

## Verification
The hardest case to reach is a NACK in the middle of a frame. The address byte has to be acknowledged and a later byte refused, so the engine has to end the frame with a stop from inside the byte loop instead of after the last byte. The bench's bus device model refuses the acknowledge on one chosen byte index. That index is set both by directed runs for each byte position and by random draws across power-up and power-down frames. A second instance with acknowledge checking disabled runs with no device on its bus, so every acknowledge slot reads high.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    localparam int unsigned FRAME_BYTES = 3;

    localparam logic [5:0] ADDR_PREFIX  = 6'b011110;
    localparam logic [7:0] CTRL_CMD     = 8'h00;
    localparam logic [7:0] OPC_DISP_ON  = 8'hAF;
    localparam logic [7:0] OPC_DISP_OFF = 8'hAE;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_RSTPULSE,
        SQ_UP_TX,
        SQ_SETTLE,
        SQ_ON,
        SQ_DN_TX
    } seq_state_e;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_START,
        EN_BIT,
        EN_STOP
    } eng_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] ctrl;
        logic [7:0] addr;
    } cmd_frame_t;

    function automatic logic [7:0] addr_byte(input logic sel);
        return {ADDR_PREFIX, sel, 1'b0};
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned khz, input int unsigned ns);
        longint unsigned t;
        t = (longint'(khz) * longint'(ns) + 64'd999999) / 64'd1000000;
        return (t < 1) ? 1 : int'(t);
    endfunction

    function automatic int unsigned us_to_cycles(input int unsigned khz, input int unsigned us);
        longint unsigned t;
        t = (longint'(khz) * longint'(us) + 64'd999) / 64'd1000;
        return (t < 1) ? 1 : int'(t);
    endfunction

    function automatic int unsigned quarter_cycles(input int unsigned khz, input int unsigned scl_khz);
        int unsigned q;
        q = khz / (4 * scl_khz);
        return (q < 2) ? 2 : q;
    endfunction

endpackage

// File: rtl/oled_i2c_writer.sv
module oled_i2c_writer
    import oled_seq_pkg::*;
#(
    parameter int unsigned NB        = 3,
    parameter int unsigned Q         = 4,
    parameter bit          CHECK_ACK = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [NB-1:0][7:0]  frame,
    input  logic                sda_in,
    output logic                scl_low,
    output logic                sda_low,
    output logic                busy,
    output logic                fin,
    output logic                nack
);
    localparam int QW = (Q > 1) ? $clog2(Q) : 1;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;

    eng_state_e     st;
    logic [1:0]     ph;
    logic [QW-1:0]  qc;
    logic [3:0]     bitn;
    logic [BW-1:0]  byten;
    logic           ackbad;
    logic           fin_q;
    logic           nack_q;

    logic tick;
    logic last_byte;
    logic cur_bit;
    logic [7:0] cur_byte;

    assign tick      = (qc == QW'(Q - 1));
    assign last_byte = (byten == BW'(NB - 1));
    assign cur_byte  = frame[byten];
    assign cur_bit   = cur_byte[3'(4'd7 - bitn)];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EN_IDLE;
            ph     <= '0;
            qc     <= '0;
            bitn   <= '0;
            byten  <= '0;
            ackbad <= 1'b0;
            fin_q  <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            fin_q  <= 1'b0;
            nack_q <= 1'b0;
            if (st == EN_IDLE) begin
                qc <= '0;
                ph <= '0;
                if (go) st <= EN_START;
            end else begin
                qc <= tick ? '0 : qc + 1'b1;
            end
            case (st)
                EN_START: begin
                    if (tick) begin
                        if (ph == 2'd1) begin
                            st     <= EN_BIT;
                            ph     <= '0;
                            bitn   <= '0;
                            byten  <= '0;
                            ackbad <= 1'b0;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                EN_BIT: begin
                    if (tick) begin
                        if (ph == 2'd1 && bitn == 4'd8) ackbad <= sda_in;
                        if (ph == 2'd3) begin
                            ph <= '0;
                            if (bitn == 4'd8) begin
                                if ((ackbad && CHECK_ACK) || last_byte) begin
                                    st <= EN_STOP;
                                end else begin
                                    byten <= byten + 1'b1;
                                    bitn  <= '0;
                                end
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                EN_STOP: begin
                    if (tick) begin
                        if (ph == 2'd2) begin
                            st     <= EN_IDLE;
                            fin_q  <= 1'b1;
                            nack_q <= ackbad && CHECK_ACK;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (st)
            EN_START: begin
                sda_low = 1'b1;
                scl_low = (ph == 2'd1);
            end
            EN_BIT: begin
                scl_low = (ph == 2'd0) || (ph == 2'd3);
                sda_low = (bitn < 4'd8) ? ~cur_bit : 1'b0;
            end
            EN_STOP: begin
                scl_low = (ph == 2'd0);
                sda_low = (ph != 2'd2);
            end
            default: ;
        endcase
    end

    assign busy = (st != EN_IDLE);
    assign fin  = fin_q;
    assign nack = nack_q;

endmodule

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
    import oled_seq_pkg::*;
#(
    parameter int unsigned RST_CYC    = 150,
    parameter int unsigned SETTLE_CYC = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        up_req,
    input  logic        down_req,
    input  logic        addr_sel,
    input  logic        fin,
    input  logic        nack,
    output logic        go,
    output cmd_frame_t  frame,
    output logic        rst_n_out,
    output logic        ready,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam int unsigned MAXC = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int CW = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

    seq_state_e     st;
    logic [CW-1:0]  cnt;
    logic           sel_q;
    logic [7:0]     opc_q;
    logic           go_q;
    logic           done_q;
    logic           err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_OFF;
            cnt    <= '0;
            sel_q  <= 1'b0;
            opc_q  <= OPC_DISP_ON;
            go_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (st)
                SQ_OFF: begin
                    if (up_req) begin
                        st    <= SQ_RSTPULSE;
                        cnt   <= '0;
                        sel_q <= addr_sel;
                        err_q <= 1'b0;
                    end
                end
                SQ_RSTPULSE: begin
                    if (cnt == CW'(RST_CYC - 1)) begin
                        st    <= SQ_UP_TX;
                        opc_q <= OPC_DISP_ON;
                        go_q  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_UP_TX: begin
                    if (fin) begin
                        if (nack) begin
                            st     <= SQ_OFF;
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            st  <= SQ_SETTLE;
                            cnt <= '0;
                        end
                    end
                end
                SQ_SETTLE: begin
                    if (cnt == CW'(SETTLE_CYC - 1)) begin
                        st     <= SQ_ON;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_ON: begin
                    if (down_req) begin
                        st    <= SQ_DN_TX;
                        opc_q <= OPC_DISP_OFF;
                        go_q  <= 1'b1;
                        err_q <= 1'b0;
                    end
                end
                SQ_DN_TX: begin
                    if (fin) begin
                        st     <= SQ_OFF;
                        err_q  <= nack;
                        done_q <= 1'b1;
                    end
                end
                default: st <= SQ_OFF;
            endcase
        end
    end

    always_comb begin
        frame.addr   = addr_byte(sel_q);
        frame.ctrl   = CTRL_CMD;
        frame.opcode = opc_q;
    end

    assign go        = go_q;
    assign rst_n_out = (st != SQ_OFF) && (st != SQ_RSTPULSE);
    assign ready     = (st == SQ_ON);
    assign busy      = (st != SQ_OFF) && (st != SQ_ON);
    assign done      = done_q;
    assign err       = err_q;

endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
    import oled_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 50000,
    parameter int unsigned RST_NS    = 3000,
    parameter int unsigned SETTLE_US = 100000,
    parameter int unsigned SCL_KHZ   = 400,
    parameter bit          CHECK_ACK = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic up_req,
    input  logic down_req,
    input  logic addr_sel,
    input  logic sda_in,
    output logic scl_low,
    output logic sda_low,
    output logic rst_n_out,
    output logic ready,
    output logic busy,
    output logic done,
    output logic err
);
    localparam int unsigned RST_CYC    = ns_to_cycles(CLK_KHZ, RST_NS);
    localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_KHZ, SETTLE_US);
    localparam int unsigned QCYC       = quarter_cycles(CLK_KHZ, SCL_KHZ);

    logic        go;
    logic        fin;
    logic        nack;
    logic        eng_busy;
    cmd_frame_t  frame;

    oled_seq_ctrl #(
        .RST_CYC    (RST_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .up_req    (up_req),
        .down_req  (down_req),
        .addr_sel  (addr_sel),
        .fin       (fin),
        .nack      (nack),
        .go        (go),
        .frame     (frame),
        .rst_n_out (rst_n_out),
        .ready     (ready),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    oled_i2c_writer #(
        .NB        (FRAME_BYTES),
        .Q         (QCYC),
        .CHECK_ACK (CHECK_ACK)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .frame   (frame),
        .sda_in  (sda_in),
        .scl_low (scl_low),
        .sda_low (sda_low),
        .busy    (eng_busy),
        .fin     (fin),
        .nack    (nack)
    );

endmodule

// File: rtl/oled_pwr_seq_chk.sv
module oled_pwr_seq_chk (
    input logic clk,
    input logic rst,
    input logic up_req,
    input logic down_req,
    input logic scl_low,
    input logic sda_low,
    input logic rst_n_out,
    input logic ready,
    input logic busy,
    input logic done,
    input logic err
);
    logic was_rst;

    always_ff @(posedge clk) was_rst <= rst;

    // R1: state right after a reset edge
    always @(posedge clk) begin
        if (was_rst && !rst) begin
            a_r1_reset_state: assert (!rst_n_out && !ready && !busy && !done && !err
                                      && !scl_low && !sda_low);
        end
    end

    a_r2_bus_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        !rst_n_out |-> (!scl_low && !sda_low));

    a_r4_ready_with_idle_bus: assert property (@(posedge clk) disable iff (rst)
        ready |-> (rst_n_out && !scl_low && !sda_low && !busy));

    a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (ready && down_req) |=> (!ready && busy));

    a_r6_err_only_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    a_r8_down_ignored_off: assert property (@(posedge clk) disable iff (rst)
        (!ready && !busy && down_req && !up_req) |=> (!busy && !ready));

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind oled_pwr_seq oled_pwr_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .up_req    (up_req),
    .down_req  (down_req),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .rst_n_out (rst_n_out),
    .ready     (ready),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/oled_pwr_seq_bench.sv
module oled_pwr_seq_bench;

    localparam int EXP_RST    = 600;   // ceil(200000 kHz * 3000 ns / 1e6)
    localparam int EXP_SETTLE = 4000;  // 200000 kHz * 20 us / 1000
    localparam int QC         = 5;     // 200000 / (4 * 10000)

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic up_req = 1'b0, down_req = 1'b0, addr_sel = 1'b0;
    logic scl_low, sda_low, rst_n_out, ready, busy, done, err;
    logic slv_low = 1'b0;
    logic scl_line, sda_line;
    assign scl_line = ~scl_low;
    assign sda_line = ~(sda_low | slv_low);

    oled_pwr_seq #(.CLK_KHZ(200000), .RST_NS(3000), .SETTLE_US(20),
                   .SCL_KHZ(10000), .CHECK_ACK(1'b1)) u_oled_pwr_seq (
        .clk(clk), .rst(rst), .up_req(up_req), .down_req(down_req),
        .addr_sel(addr_sel), .sda_in(sda_line), .scl_low(scl_low),
        .sda_low(sda_low), .rst_n_out(rst_n_out), .ready(ready),
        .busy(busy), .done(done), .err(err));

    // second instance, acknowledge check disabled, nothing answers on its bus
    logic up2 = 1'b0;
    logic scl2, sda2, rstn2, ready2, busy2, done2, err2;
    oled_pwr_seq #(.CLK_KHZ(200000), .RST_NS(3000), .SETTLE_US(20),
                   .SCL_KHZ(10000), .CHECK_ACK(1'b0)) u_oled_pwr_seq_noack (
        .clk(clk), .rst(rst), .up_req(up2), .down_req(1'b0),
        .addr_sel(1'b1), .sda_in(~sda2), .scl_low(scl2),
        .sda_low(sda2), .rst_n_out(rstn2), .ready(ready2),
        .busy(busy2), .done(done2), .err(err2));

    // bus device model
    int   cyc = 0;
    int   nack_at = -1;
    logic clr_slv = 1'b0;
    logic [7:0] rx [0:7];
    int   nbytes, starts, stops, stop_cyc;
    logic [7:0] shreg;
    int   bitc;
    logic ackph;
    logic pscl = 1'b1, psda = 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        pscl <= scl_line;
        psda <= sda_line;
        if (clr_slv) begin
            nbytes <= 0; starts <= 0; stops <= 0; stop_cyc <= 0;
            bitc <= 0; ackph <= 1'b0; slv_low <= 1'b0;
        end else if (pscl && scl_line && psda && !sda_line) begin
            starts <= starts + 1; bitc <= 0; ackph <= 1'b0;
        end else if (pscl && scl_line && !psda && sda_line) begin
            stops <= stops + 1; stop_cyc <= cyc;
        end else if (!pscl && scl_line) begin
            if (!ackph && bitc < 8) begin
                shreg <= {shreg[6:0], sda_line};
                bitc  <= bitc + 1;
            end
        end else if (pscl && !scl_line) begin
            if (!ackph && bitc == 8) begin
                if (nbytes < 8) rx[nbytes] <= shreg;
                slv_low <= (nbytes != nack_at);
                nbytes  <= nbytes + 1;
                ackph   <= 1'b1;
            end else if (ackph) begin
                slv_low <= 1'b0;
                ackph   <= 1'b0;
                bitc    <= 0;
            end
        end
    end

    int checks = 0, fails = 0;
    bit timed_out = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_byte(input logic sel, input int idx, input logic [7:0] opc);
        case (idx)
            0: return {24'd0, 6'b011110, sel, 1'b0};
            1: return 0;
            default: return {24'd0, opc};
        endcase
    endfunction

    task automatic clear_slave(input int nk);
        @(negedge clk); nack_at = nk; clr_slv = 1'b1;
        @(negedge clk); clr_slv = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        if (!ok) begin timed_out = 1'b1; chk(1'b0, "R9", "done timeout", 0, 1); end
    endtask

    task automatic check_frame(input string req, input logic sel, input logic [7:0] opc, input int nk);
        int expn;
        expn = (nk >= 0 && nk < 3) ? nk + 1 : 3;
        chk(nbytes == expn, (nk >= 0 && nk < 3) ? "R6" : req, "byte count", nbytes, expn);
        chk(starts == 1 && stops == 1, "R3", "start/stop count", starts * 10 + stops, 11);
        for (int i = 0; i < 3; i++)
            if (i < nbytes) chk(rx[i] == exp_byte(sel, i, opc), req, "frame byte", rx[i], exp_byte(sel, i, opc));
    endtask

    task automatic power_up(input logic sel, input int nk);
        int lowc; bit act; bit ok; int c0;
        clear_slave(nk);
        addr_sel = sel;
        @(negedge clk); up_req = 1'b1;
        @(negedge clk); up_req = 1'b0;
        chk(busy, "R9", "busy after up request", busy, 1);
        lowc = 0; act = 1'b0;
        while (!rst_n_out && lowc < 5000) begin
            if (scl_low || sda_low) act = 1'b1;
            lowc++;
            @(negedge clk);
        end
        chk(lowc >= EXP_RST && lowc <= EXP_RST + 1, "R2", "reset low cycles", lowc, EXP_RST);
        chk(!act, "R2", "bus activity during reset", act, 0);
        wait_done(ok);
        if (!ok) return;
        check_frame("R3", sel, 8'hAF, nk);
        if (nk >= 0 && nk < 3) begin
            chk(err && !ready && !rst_n_out, "R6", "nack result err/ready/rstn",
                {err, ready, rst_n_out}, 3'b100);
        end else begin
            c0 = cyc - stop_cyc;
            chk(c0 >= EXP_SETTLE && c0 <= EXP_SETTLE + QC + 4, "R4", "settle after stop", c0, EXP_SETTLE);
            chk(ready && !err && !busy, "R4", "ready/err/busy at done", {ready, err, busy}, 3'b100);
        end
        @(negedge clk);
        chk(!done, "R9", "done is one cycle", done, 0);
    endtask

    task automatic power_down(input logic sel, input int nk);
        bit ok;
        clear_slave(nk);
        @(negedge clk); down_req = 1'b1;
        @(negedge clk); down_req = 1'b0;
        chk(!ready && busy, "R5", "ready drops at down request", ready, 0);
        wait_done(ok);
        if (!ok) return;
        check_frame("R5", sel, 8'hAE, nk);
        chk(err == (nk >= 0 && nk < 3), "R5", "err after down", err, (nk >= 0 && nk < 3));
        chk(!rst_n_out && !ready, "R5", "reset held after down", rst_n_out, 0);
    endtask

    task automatic idle_watch(input string req, input logic exp_ready);
        int s0;
        s0 = starts;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_low || sda_low || busy || ready != exp_ready) break;
        end
        chk(starts == s0 && !scl_low && !sda_low && !busy && ready == exp_ready,
            req, "ignored request changed state", {busy, ready}, {1'b0, exp_ready});
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        timed_out = 1'b1;
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic rsel; int nk; bit ok;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rst_n_out && !ready && !busy && !done && !err && !scl_low && !sda_low,
            "R1", "reset state", {rst_n_out, ready, busy, done, err, scl_low, sda_low}, 0);

        clear_slave(-1);
        @(negedge clk); down_req = 1'b1;
        @(negedge clk); down_req = 1'b0;
        idle_watch("R8", 1'b0);
        chk(!rst_n_out, "R8", "rstn after ignored down", rst_n_out, 0);

        for (int it = 0; it < 9 && !timed_out; it++) begin
            rsel = 1'($urandom);
            case (it)
                1: nk = 0;
                2: nk = 1;
                3: nk = 2;
                default: nk = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
            endcase
            power_up(rsel, nk);
            if (timed_out) break;
            if (ready) begin
                clear_slave(-1);
                @(negedge clk); up_req = 1'b1;
                @(negedge clk); up_req = 1'b0;
                idle_watch("R8", 1'b1);
                nk = (it == 5) ? 2 : ((it == 6) ? 0 : -1);
                power_down(rsel, nk);
            end
        end

        // R7: acknowledge check disabled, no device answers
        @(negedge clk); up2 = 1'b1;
        @(negedge clk); up2 = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done2) begin ok = 1'b1; break; end
        end
        chk(ok && ready2 && !err2, "R7", "no-ack instance ready/err", {ready2, err2}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule